// File: doc/BRIEF.md
# Vertical-Blank Sprite List Copier

The block moves a sprite attribute list out of CPU work RAM into a buffer that is private to the sprite renderer. The CPU asks for a copy by writing to one I/O port; the value written does not matter, only the address. Because the list sits in the same RAM device the CPU uses for its own variables, the copier borrows that RAM through a request/grant pair. It reads one byte in every cycle where the grant is given, walking the list from its first byte to its last.

A copy only runs while vertical blanking is active. A request made during the visible frame is held and carried out once blanking is seen. Requests that arrive while a copy is running fold into one held request. The private buffer has two banks. The renderer always reads the front bank, the copier fills the back bank, and the two trade places only when a copy has read every byte. If blanking ends before the last byte, the copy is dropped and the renderer keeps the list it already had, so it never draws from a half-written list.

Top module: `spr_list_copier`

## Requirements
- R1: After reset, `busy` is 0, `ram_req` is 0, `bank_sel` is 0 and no copy request is held.
- R2: A copy is requested by a cycle with `io_wr` high and `io_addr` equal to `TRIG_PORT` (default 8'h06). A write to any other address has no effect.
- R3: If the copier is idle and a request is seen or held while `vblank` is 1, `busy` is 1 from the next clock edge on. `ram_req` equals `busy` AND `vblank`.
- R4: A request seen while `vblank` is 0 is held. The copy starts at the edge of the first cycle in which `vblank` is 1, so `busy` is 1 after that edge.
- R5: During a copy, `ram_addr` equals `SRC_BASE` plus a byte index. The index starts at 0 and goes up by one after each cycle with `ram_req` and `ram_gnt` both 1. A full copy covers `NUM_SPR*SPR_BYTES` bytes, 512 by default.
- R6: The byte on `ram_rdata` in a granted cycle is stored at the current index of the back bank, which is the bank that `bank_sel` does not select.
- R7: On the edge that stores the last byte, `busy` returns to 0 and `bank_sel` toggles. `bank_sel` changes at no other time.
- R8: If `vblank` is 0 while `busy` is 1, the copy is dropped: `busy` is 0 after the next edge, `bank_sel` keeps its value, and the dropped copy is not retried.
- R9: Any number of requests made while a copy runs leave exactly one held request. That request is carried out once the running copy ends, following R3 and R4.
- R10: `rd_data` holds the front-bank byte at `rd_addr` one clock after `rd_addr` is presented.
- R11: `bank_sel` tells which bank the renderer is reading: 0 for the lower bank, 1 for the upper bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | CPU I/O write strobe |
| io_addr | input | IOW (8) | CPU I/O address |
| vblank | input | 1 | Vertical blanking active |
| ram_req | output | 1 | Work RAM bus request |
| ram_gnt | input | 1 | Work RAM bus grant; the read data is valid in the same cycle |
| ram_addr | output | AW (12) | Work RAM byte address |
| ram_rdata | input | DW (8) | Work RAM read data |
| rd_addr | input | IW (9) | Renderer read index into the front bank |
| rd_data | output | DW (8) | Renderer read data, one cycle latency |
| busy | output | 1 | A copy is in progress |
| bank_sel | output | 1 | Bank the renderer currently reads |

## Verification
The hardest case to reach from the ports is the boundary between copies. One case is a request held from a running copy that starts the cycle after the last byte. The other is a copy that blanking cuts short partway through, which must leave the front bank untouched. To reach these, the stimulus sends several requests during one alternating-grant copy and then watches the single idle cycle before the held copy starts. It then drops `vblank` halfway through a copy, and later runs frames with random grants and random request times, where copies both complete and abort. A behavioural model in the bench tracks both banks byte by byte and is compared with the ports on every clock.

// File: rtl/spr_copy_pkg.sv
package spr_copy_pkg;

  typedef enum logic {CP_IDLE = 1'b0, CP_RUN = 1'b1} cp_state_e;

  // Decode of the CPU write that requests a copy.
  function automatic logic is_trigger(input logic wr, input logic [31:0] addr,
                                      input logic [31:0] port);
    return wr && (addr == port);
  endfunction

  // Work RAM byte address for a list index.
  function automatic logic [31:0] list_src_addr(input logic [31:0] base,
                                                input logic [31:0] idx);
    return base + idx;
  endfunction

  // Buffer word index for a bank and byte index (total is a power of two).
  function automatic logic [31:0] buf_index(input logic bank, input logic [31:0] idx,
                                            input logic [31:0] total);
    return (bank ? total : 32'd0) + idx;
  endfunction

endpackage

// File: rtl/spr_copy_ctl.sv
module spr_copy_ctl
  import spr_copy_pkg::*;
#(
  parameter int IOW       = 8,
  parameter int TRIG_PORT = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           io_wr,
  input  logic [IOW-1:0] io_addr,
  input  logic           vblank,
  input  logic           last_beat,
  output logic           busy,
  output logic           start,
  output logic           done,
  output logic           abort
);

  cp_state_e state_q;
  logic      pend_q;
  logic      trig;

  assign trig  = is_trigger(io_wr, {{(32-IOW){1'b0}}, io_addr}, TRIG_PORT);
  assign start = (state_q == CP_IDLE) && vblank && (pend_q || trig);
  assign abort = (state_q == CP_RUN) && !vblank;
  assign done  = (state_q == CP_RUN) && last_beat;
  assign busy  = (state_q == CP_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CP_IDLE;
      pend_q  <= 1'b0;
    end else begin
      if (start) begin
        state_q <= CP_RUN;
        pend_q  <= 1'b0;
      end else begin
        if (abort || done) state_q <= CP_IDLE;
        if (trig)          pend_q  <= 1'b1;
      end
    end
  end

  // R9
  merge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig) |=> pend_q);

  // R4
  hold_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !vblank && trig) |=> (pend_q && !busy));

endmodule

// File: rtl/spr_addr_walk.sv
module spr_addr_walk
  import spr_copy_pkg::*;
#(
  parameter int TOTAL    = 512,
  parameter int AW       = 12,
  parameter int SRC_BASE = 'hC00,
  localparam int IW      = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          beat,
  output logic [IW-1:0] idx,
  output logic          last,
  output logic [AW-1:0] ram_addr
);

  logic [31:0] addr_full;

  assign last      = (idx == IW'(TOTAL - 1));
  assign addr_full = list_src_addr(SRC_BASE, {{(32-IW){1'b0}}, idx});
  assign ram_addr  = addr_full[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)                idx <= '0;
    else if (start)            idx <= '0;
    else if (beat && !last)    idx <= idx + IW'(1);
  end

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (idx == '0));

endmodule

// File: rtl/spr_dbl_buf.sv
module spr_dbl_buf
  import spr_copy_pkg::*;
#(
  parameter int TOTAL = 512,
  parameter int DW    = 8,
  localparam int IW   = $clog2(TOTAL),
  localparam int DEPTH = 2 * TOTAL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          swap,
  input  logic [IW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          front
);

  logic [DW-1:0] mem [DEPTH];
  logic [31:0]   wr_pos;
  logic [31:0]   rd_pos;

  assign wr_pos = buf_index(!front, {{(32-IW){1'b0}}, wr_idx}, TOTAL);
  assign rd_pos = buf_index(front,  {{(32-IW){1'b0}}, rd_addr}, TOTAL);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_pos[IW:0]] <= wr_data;
    rd_data <= mem[rd_pos[IW:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    front <= 1'b0;
    else if (swap) front <= !front;
  end

  initial begin
    // R5
    pow2_chk: assert ((1 << IW) == TOTAL);
  end

endmodule

// File: rtl/spr_list_copier.sv
module spr_list_copier
  import spr_copy_pkg::*;
#(
  parameter int NUM_SPR   = 128,
  parameter int SPR_BYTES = 4,
  parameter int AW        = 12,
  parameter int DW        = 8,
  parameter int IOW       = 8,
  parameter int TRIG_PORT = 6,
  parameter int SRC_BASE  = 'hC00,
  localparam int TOTAL    = NUM_SPR * SPR_BYTES,
  localparam int IW       = $clog2(TOTAL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           io_wr,
  input  logic [IOW-1:0] io_addr,
  input  logic           vblank,
  output logic           ram_req,
  input  logic           ram_gnt,
  output logic [AW-1:0]  ram_addr,
  input  logic [DW-1:0]  ram_rdata,
  input  logic [IW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           busy,
  output logic           bank_sel
);

  // Named internal events for the checks.
  logic          ev_start;
  logic          ev_done;
  logic          ev_abort;
  logic          ev_beat;
  logic          ev_last_beat;
  logic          at_last;
  logic [IW-1:0] idx;

  assign ram_req      = busy && vblank;
  assign ev_beat      = ram_req && ram_gnt;
  assign ev_last_beat = ev_beat && at_last;

  spr_copy_ctl #(.IOW(IOW), .TRIG_PORT(TRIG_PORT)) ctl_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .vblank(vblank), .last_beat(ev_last_beat), .busy(busy),
    .start(ev_start), .done(ev_done), .abort(ev_abort)
  );

  spr_addr_walk #(.TOTAL(TOTAL), .AW(AW), .SRC_BASE(SRC_BASE)) walk_i (
    .clk(clk), .rst_n(rst_n), .start(ev_start), .beat(ev_beat),
    .idx(idx), .last(at_last), .ram_addr(ram_addr)
  );

  spr_dbl_buf #(.TOTAL(TOTAL), .DW(DW)) buf_i (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_beat), .wr_idx(idx),
    .wr_data(ram_rdata), .swap(ev_done), .rd_addr(rd_addr),
    .rd_data(rd_data), .front(bank_sel)
  );

  // R3
  start_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(vblank));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_beat && !at_last) |=> (ram_addr == $past(ram_addr) + AW'(1)));

  // R7
  swap_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel != $past(bank_sel)) |-> ($fell(busy) && $past(vblank)));

  // R8
  abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !vblank) |=> (!busy && $stable(bank_sel)));

  // R3
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req |-> (busy && vblank));

endmodule

// File: tb/spr_list_copier_tb.sv
module spr_list_copier_tb_top;

  localparam int CLK_P = 10;
  localparam int TOTAL = 512;
  localparam int SRC   = 'hC00;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_wr = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic       vblank = 1'b0;
  logic       ram_req;
  logic       ram_gnt = 1'b0;
  logic [11:0] ram_addr;
  logic [7:0] ram_rdata;
  logic [8:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy;
  logic       bank_sel;

  int checks = 0;
  int failures = 0;
  int gen = 1;
  int gnt_mode = 0;
  bit rd_hold = 0;
  bit finished = 0;
  bit toggle = 0;

  // behavioural reference model
  bit   m_busy, m_pend, m_front;
  int   m_idx;
  logic [7:0] m_mem [2][TOTAL];
  bit   m_val [2][TOTAL];
  logic [7:0] m_rd;
  bit   m_rd_val;

  function automatic logic [7:0] wbyte(input int a, input int g);
    return 8'((a * 5) + (g * 29) + (a >> 7));
  endfunction

  assign ram_rdata = wbyte(int'(ram_addr), gen);

  always #(CLK_P/2) clk = ~clk;

  spr_list_copier dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .vblank(vblank), .ram_req(ram_req), .ram_gnt(ram_gnt),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .bank_sel(bank_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // model update on every edge
  always @(posedge clk) begin
    bit trig, beat;
    trig = io_wr && (io_addr == 8'h06);
    beat = m_busy && vblank && ram_gnt;
    m_rd = m_mem[m_front][rd_addr];
    m_rd_val = m_val[m_front][rd_addr];
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_front = 0; m_idx = 0;
    end else if (m_busy) begin
      if (!vblank) m_busy = 0;
      else if (beat) begin
        m_mem[!m_front][m_idx] = wbyte(SRC + m_idx, gen);
        m_val[!m_front][m_idx] = 1;
        if (m_idx == TOTAL - 1) begin m_busy = 0; m_front = !m_front; end
        else m_idx++;
      end
      if (trig) m_pend = 1;
    end else begin
      if (vblank && (m_pend || trig)) begin m_busy = 1; m_idx = 0; m_pend = 0; end
      else if (trig) m_pend = 1;
    end
  end

  // compare every clock, between the edge and the next input change
  always @(posedge clk) begin
    #(CLK_P*3/10);
    if (rst_n && !finished) begin
      chk(busy === m_busy, "R3 busy", int'(busy), int'(m_busy));
      chk(ram_req === (m_busy && vblank), "R3 ram_req", int'(ram_req), int'(m_busy && vblank));
      if (m_busy) chk(ram_addr === 12'(SRC + m_idx), "R5 ram_addr", int'(ram_addr), SRC + m_idx);
      chk(bank_sel === m_front, "R11 bank_sel", int'(bank_sel), int'(m_front));
      if (m_rd_val) chk(rd_data === m_rd, "R10 rd_data", int'(rd_data), int'(m_rd));
    end
  end

  task automatic tick();
    @(negedge clk);
    if (!rd_hold) rd_addr = rd_addr + 9'd1;
    toggle = !toggle;
    case (gnt_mode)
      0: ram_gnt = 1'b1;
      1: ram_gnt = toggle;
      default: ram_gnt = ($urandom % 3) != 0;
    endcase
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse(input logic [7:0] a);
    io_addr = a; io_wr = 1'b1;
    tick();
    io_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) tick();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    for (int b = 0; b < 2; b++) for (int i = 0; i < TOTAL; i++) m_val[b][i] = 0;
    ticks(3);
    // R1 reset state
    chk(busy == 0 && ram_req == 0 && bank_sel == 0, "R1 reset outputs",
        {busy, ram_req, bank_sel}, 0);
    rst_n = 1'b1;
    tick();

    // R3: request in blanking starts next edge; full copy swaps (R7)
    vblank = 1'b1;
    pulse(8'h06);
    chk(busy == 1, "R3 start in blank", int'(busy), 1);
    wait_idle();
    chk(busy == 0 && bank_sel == 1, "R7 swap after full copy", {busy, bank_sel}, 1);
    // R6: byte 3 of the list now readable in the new front bank
    rd_hold = 1; rd_addr = 9'd3;
    ticks(2);
    chk(rd_data == wbyte(SRC + 3, gen), "R6 stored byte", int'(rd_data), int'(wbyte(SRC + 3, gen)));
    rd_hold = 0;

    // R2: other port ignored
    pulse(8'h05);
    ticks(2);
    chk(busy == 0, "R2 other port", int'(busy), 0);

    // R4: request outside blanking held
    gen++;
    vblank = 1'b0;
    pulse(8'h06);
    ticks(3);
    chk(busy == 0, "R4 held outside blank", int'(busy), 0);
    vblank = 1'b1;
    tick();
    chk(busy == 1, "R4 start on blank", int'(busy), 1);
    wait_idle();
    chk(bank_sel == 0, "R7 second swap", int'(bank_sel), 0);

    // R9: several requests during a copy merge into one
    gen++; gnt_mode = 1;
    pulse(8'h06);
    ticks(10);
    pulse(8'h06);
    ticks(5);
    pulse(8'h06);
    wait_idle();
    chk(busy == 0, "R9 gap cycle", int'(busy), 0);
    tick();
    chk(busy == 1, "R9 held copy starts", int'(busy), 1);
    wait_idle();
    ticks(3);
    chk(busy == 0, "R9 only one extra copy", int'(busy), 0);
    chk(bank_sel == 0, "R7 two swaps", int'(bank_sel), 0);

    // R8: end of blanking drops the copy
    gen++; gnt_mode = 0;
    pulse(8'h06);
    ticks(50);
    vblank = 1'b0;
    tick();
    chk(busy == 0, "R8 abort", int'(busy), 0);
    chk(bank_sel == 0, "R8 no swap", int'(bank_sel), 0);
    vblank = 1'b1;
    ticks(3);
    chk(busy == 0, "R8 no retry", int'(busy), 0);

    // random grants and request times over several frames
    gnt_mode = 2;
    for (int f = 0; f < 8; f++) begin
      gen++;
      vblank = 1'b0;
      for (int c = 0; c < 300; c++) begin
        if (($urandom % 97) == 0) pulse(($urandom % 4 == 0) ? 8'h07 : 8'h06);
        else tick();
      end
      vblank = 1'b1;
      for (int c = 0; c < 700 + f * 60; c++) begin
        if (($urandom % 211) == 0) pulse(8'h06);
        else tick();
      end
    end
    vblank = 1'b1;
    wait_idle();
    ticks(4);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R3 watchdog act=hung exp=done");
      finish_run();
    end
  end

endmodule